// File: doc/BRIEF.md
# Serialized Interrupt Host Start Controller

This block is the host end of a shared, open-drain serialized interrupt line. It brings every cycle on that line into line: it opens each cycle with a start frame, then steps through a fixed number of three-clock slots. In each slot it reads the line during the sample clock and stores the level as one bit of a parallel request vector. It closes the cycle with a stop frame. The line leaves the block through two separate enables, one that pulls the line low and one that drives it high. When neither enable is set, an external pull-up holds the line high.

The block has two modes. In continuous mode the host opens every cycle itself, and this is the mode it enters after reset. In quiet mode the host waits until a peripheral pulls the line low for one clock. It then takes over that start frame and completes it. The stop frame selects the mode for the next cycle: a short stop enters quiet mode and a longer stop keeps continuous mode. A configuration input sets the total low time of a start frame. That time includes the clock a peripheral may already have driven.

Top module: `serint_host_ctl`

## Requirements
- R1: While reset is asserted and in the first clock after it, both drive enables are off and every request bit is 0. The mode is continuous.
- R2: In continuous mode the host drives the line low for 4 + `cfg_width` clocks, for `cfg_width` values 0 to 4. It then drives the line high for exactly one clock.
- R3: `cfg_width` values 5, 6 and 7 all give a start low time of 8 clocks. No low drive ever lasts longer than 8 clocks.
- R4: After the start high clock the host releases the line for one turn-around clock. It then releases the line for NSLOT slots of three clocks each. The first clock of each slot is the sample clock.
- R5: At the end of the sample clock of slot i, `irq_req[i]` becomes 1 if the line is low and 0 if it is high. A released line therefore reads as 0. A bit changes at no other time.
- R6: If `cfg_quiet` is 0 at the end of the last slot, the stop frame is 3 low clocks and then 1 high clock. After one released clock, a new start frame follows.
- R7: If `cfg_quiet` is 1 at the end of the last slot, the stop frame is 2 low clocks and then 1 high clock. The block then enters quiet mode.
- R8: In quiet mode, if the line is low in a clock where the host is not driving, the host drives the line low from the next clock for the programmed width minus one clock. It then drives the line high for one clock, and the slots follow as in R4.
- R9: The two enables are never on together. After a high clock, the host releases the line.
- R10: In quiet mode, while the line stays high, the host keeps both enables off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_width | input | 3 | Start low time code: 4 + code clocks, with codes above 4 giving 8 clocks |
| cfg_quiet | input | 1 | Selects the stop-frame length, and so the mode for the next cycle (1 = quiet) |
| line_in | input | 1 | Level read back from the shared line |
| drv_low | output | 1 | Enable that pulls the line low |
| drv_high | output | 1 | Enable that drives the line high |
| irq_req | output | NSLOT | Request bit for each slot, 1 = active |

## Verification
The assertions assume that `line_in` reads low whenever `drv_low` is set. They also assume that no peripheral drives the line low during a host high clock or outside sample clocks and takeover pulses. The bench meets these assumptions by building the line as the wired-AND of the host low enable, a single peripheral pull-down and a pull-up. It sets the peripheral pull-down only during a sample clock or for the single quiet-mode wake pulse, and clears it again one clock later. The bench sweeps all width codes in both modes against zero, all-ones, walking and alternating slot patterns.

// File: rtl/serint_pkg.sv
package serint_pkg;

  typedef enum logic [2:0] {
    ST_GAP,
    ST_QIDLE,
    ST_SLOW,
    ST_SHIGH,
    ST_STA,
    ST_SLOT,
    ST_PLOW,
    ST_PHIGH
  } sirq_state_e;

  localparam int CNT_W = 4;

  // total start low clocks for a width code; codes above 4 saturate at 8
  function automatic logic [CNT_W-1:0] start_len(input logic [2:0] code);
    return (code > 3'd4) ? 4'd8 : (4'd4 + {1'b0, code});
  endfunction

endpackage

// File: rtl/serint_fsm.sv
module serint_fsm
  import serint_pkg::*;
#(
  parameter int NSLOT = 17,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cfg_width,
  input  logic             cfg_quiet,
  input  logic             line_in,
  output logic             drv_low_o,
  output logic             drv_high_o,
  output logic             samp_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSLOT - 1);

  sirq_state_e      state, nxt;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [1:0]       phase, phase_n;
  logic [IDX_W-1:0] idx, idx_n;
  logic             quiet_q, quiet_n;

  always_comb begin
    nxt     = state;
    cnt_n   = cnt;
    phase_n = phase;
    idx_n   = idx;
    quiet_n = quiet_q;
    case (state)
      ST_GAP: begin
        nxt   = ST_SLOW;
        cnt_n = start_len(cfg_width);
      end
      ST_QIDLE: begin
        if (!line_in) begin
          nxt   = ST_SLOW;
          cnt_n = start_len(cfg_width) - 4'd1;
        end
      end
      ST_SLOW: begin
        if (cnt == 4'd1) nxt = ST_SHIGH;
        else             cnt_n = cnt - 4'd1;
      end
      ST_SHIGH: nxt = ST_STA;
      ST_STA: begin
        nxt     = ST_SLOT;
        phase_n = 2'd0;
        idx_n   = '0;
      end
      ST_SLOT: begin
        if (phase == 2'd2) begin
          phase_n = 2'd0;
          if (idx == LAST_IDX) begin
            nxt     = ST_PLOW;
            cnt_n   = cfg_quiet ? 4'd2 : 4'd3;
            quiet_n = cfg_quiet;
          end else begin
            idx_n = idx + 1'b1;
          end
        end else begin
          phase_n = phase + 2'd1;
        end
      end
      ST_PLOW: begin
        if (cnt == 4'd1) nxt = ST_PHIGH;
        else             cnt_n = cnt - 4'd1;
      end
      ST_PHIGH: nxt = quiet_q ? ST_QIDLE : ST_GAP;
      default:  nxt = ST_GAP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_GAP;
      cnt        <= '0;
      phase      <= '0;
      idx        <= '0;
      quiet_q    <= 1'b0;
      drv_low_o  <= 1'b0;
      drv_high_o <= 1'b0;
    end else begin
      state      <= nxt;
      cnt        <= cnt_n;
      phase      <= phase_n;
      idx        <= idx_n;
      quiet_q    <= quiet_n;
      drv_low_o  <= (nxt == ST_SLOW) || (nxt == ST_PLOW);
      drv_high_o <= (nxt == ST_SHIGH) || (nxt == ST_PHIGH);
    end
  end

  assign samp_o = (state == ST_SLOT) && (phase == 2'd0);
  assign idx_o  = idx;

  // consecutive low-drive run length, for the width bound
  logic [CNT_W-1:0] low_run;
  always_ff @(posedge clk) begin
    if (rst)            low_run <= '0;
    else if (drv_low_o) low_run <= low_run + 4'd1;
    else                low_run <= '0;
  end

  AST_DRV_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(drv_low_o && drv_high_o)); // R9
  AST_HIGH_RELEASE: assert property (@(posedge clk) disable iff (rst)
    drv_high_o |=> (!drv_high_o && !drv_low_o)); // R9
  AST_LOW_ENDS_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_low_o) |-> drv_high_o); // R2
  AST_LOW_MAX: assert property (@(posedge clk) disable iff (rst)
    drv_low_o |-> (low_run < 4'd8)); // R3
  AST_QUIET_TAKEOVER: assert property (@(posedge clk) disable iff (rst)
    (state == ST_QIDLE && !line_in) |=> drv_low_o); // R8
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_QIDLE && line_in) |=> (!drv_low_o && !drv_high_o)); // R10
  AST_SLOT_RELEASED: assert property (@(posedge clk) disable iff (rst)
    samp_o |-> (!drv_low_o && !drv_high_o)); // R4

endmodule

// File: rtl/serint_capture.sv
module serint_capture #(
  parameter int NSLOT = 17,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             samp_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             line_i,
  output logic [NSLOT-1:0] req_o
);

  for (genvar g = 0; g < NSLOT; g++) begin : g_bit
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    always_ff @(posedge clk) begin
      if (rst)                           req_o[g] <= 1'b0;
      else if (samp_i && idx_i == MY_IDX) req_o[g] <= ~line_i;
    end
  end

  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    samp_i |=> (req_o[$past(idx_i)] == !$past(line_i))); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !samp_i |=> $stable(req_o)); // R5

endmodule

// File: rtl/serint_host_ctl.sv
module serint_host_ctl #(
  parameter int NSLOT = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cfg_width,
  input  logic             cfg_quiet,
  input  logic             line_in,
  output logic             drv_low,
  output logic             drv_high,
  output logic [NSLOT-1:0] irq_req
);

  localparam int IDX_W = (NSLOT > 2) ? $clog2(NSLOT) : 1;

  logic             samp;
  logic [IDX_W-1:0] idx;

  serint_fsm #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .cfg_width  (cfg_width),
    .cfg_quiet  (cfg_quiet),
    .line_in    (line_in),
    .drv_low_o  (drv_low),
    .drv_high_o (drv_high),
    .samp_o     (samp),
    .idx_o      (idx)
  );

  serint_capture #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_capture (
    .clk    (clk),
    .rst    (rst),
    .samp_i (samp),
    .idx_i  (idx),
    .line_i (line_in),
    .req_o  (irq_req)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!drv_low && !drv_high && irq_req == '0)); // R1

endmodule

// File: tb/serint_host_ctl_bench.sv
`timescale 1ns/1ps
module serint_host_ctl_bench;

  localparam int NS = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    cfg_width = 3'd0;
  logic          cfg_quiet = 1'b0;
  logic          periph_low = 1'b0;
  logic          drv_low, drv_high;
  logic [NS-1:0] irq_req;
  logic          line_in;

  int checks = 0;
  int errors = 0;

  assign line_in = !(drv_low || periph_low);

  always #4 clk = ~clk;

  serint_host_ctl #(.NSLOT(NS)) u_serint_host_ctl (
    .clk       (clk),
    .rst       (rst),
    .cfg_width (cfg_width),
    .cfg_quiet (cfg_quiet),
    .line_in   (line_in),
    .drv_low   (drv_low),
    .drv_high  (drv_high),
    .irq_req   (irq_req)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check_drv(input bit el, input bit eh, input string req);
    checks++;
    if (drv_low !== el || drv_high !== eh) begin
      errors++;
      $display("FAIL %s: low/high=%b%b expected %b%b at %0t", req, drv_low, drv_high, el, eh, $time);
    end
  endtask

  task automatic check_irq(input logic [NS-1:0] exp, input string req);
    checks++;
    if (irq_req !== exp) begin
      errors++;
      $display("FAIL %s: irq_req=%h expected %h", req, irq_req, exp);
    end
  endtask

  function automatic logic [NS-1:0] pat_of(input int code, input int p);
    logic [NS-1:0] v;
    v = '0;
    case (p)
      0: v = '0;
      1: v = '1;
      2: v[(code * 2 + 1) % NS] = 1'b1;
      3: begin v = '1; v[(code * 3 + 2) % NS] = 1'b0; end
      default: for (int i = 0; i < NS; i++) v[i] = ((i + code) % 2) == 1;
    endcase
    return v;
  endfunction

  // checks from the first start low clock through the stop high clock
  task automatic run_frame(input int code, input bit q_after, input bit take, input logic [NS-1:0] pat);
    int w;
    int lows;
    int nstop;
    w = 4 + ((code > 4) ? 4 : code);
    lows = take ? w - 1 : w;
    nstop = q_after ? 2 : 3;
    cfg_quiet = q_after;
    for (int i = 0; i < lows; i++) begin
      check_drv(1, 0, take ? "R8" : ((code > 4) ? "R3" : "R2"));
      step();
    end
    check_drv(0, 1, "R2");
    step();
    check_drv(0, 0, "R4");
    step();
    for (int s = 0; s < NS; s++) begin
      check_drv(0, 0, "R4");
      periph_low = pat[s];
      step();
      periph_low = 1'b0;
      check_drv(0, 0, "R4");
      step();
      check_drv(0, 0, "R4");
      step();
    end
    for (int i = 0; i < nstop; i++) begin
      check_drv(1, 0, q_after ? "R7" : "R6");
      step();
    end
    check_drv(0, 1, q_after ? "R7" : "R6");
    check_irq(pat, "R5");
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    check_drv(0, 0, "R1");
    check_irq('0, "R1");
    rst = 1'b0;
    step();
    // continuous sweep over all width codes and patterns
    for (int f = 0; f < 40; f++) begin
      run_frame(f / 5, f == 39, 0, pat_of(f / 5, f % 5));
      if (f != 39) begin
        cfg_width = 3'((f + 1) / 5);
        check_drv(0, 0, "R6");
        step();
      end
    end
    // quiet idle: host stays off
    for (int i = 0; i < 20; i++) begin
      check_drv(0, 0, "R10");
      step();
    end
    // quiet takeovers for every width code
    for (int c = 0; c < 8; c++) begin
      cfg_width = 3'(c);
      periph_low = 1'b1;
      check_drv(0, 0, "R8");
      step();
      periph_low = 1'b0;
      run_frame(c, c != 7, 1, pat_of(c, (c + 2) % 5));
      if (c != 7) begin
        for (int i = 0; i < 3; i++) begin
          check_drv(0, 0, "R10");
          step();
        end
      end
    end
    // back in continuous mode: gap then a host-started frame
    cfg_width = 3'd2;
    check_drv(0, 0, "R6");
    step();
    run_frame(2, 0, 0, pat_of(5, 4));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule